// File: doc/BRIEF.md
# SPI Register Port for a Real-Time-Clock Model

This block is the serial front end of a real-time-clock model. An SPI master drives it with a single transaction per chip-select window. The first byte of each transaction is a command. Its top bit chooses the direction and its low seven bits give a starting register address. Every later byte in the same window is written to, or read from, that address. The address then advances by one for each byte.

Behind the port sits a 128-byte register space:

- time and date bytes;
- two alarm banks;
- a control byte and a status byte;
- a trickle-charger configuration byte;
- a 96-byte general-purpose memory.

A write-protect flag in the control byte locks every register except the control byte itself. Reserved control and status bits read as zero. The unused gap between the trickle byte and the memory neither stores nor returns data.

All serial inputs are brought into the system clock domain through synchronizer flops. Serial-clock edges are then detected in that domain, so the system clock must run several times faster than the serial clock.

Top module: `rtc_spi_slave`

## Requirements
- R1: The first byte after chip select rises is a command. A 1 in bit 7 selects a write and a 0 selects a read. Bits 6..0 give the starting address. All bytes travel most significant bit first.
- R2: The serial clock idles low. MOSI is sampled on each falling serial-clock edge. MISO changes after each rising edge, so bit 7 of a read byte is valid from the first rising edge of that byte onward.
- R3: Each data byte moves the address up by one. Address 0x7F is followed by 0x00.
- R4: Addresses 0x00–0x0E (time and alarms), 0x11 (trickle configuration) and 0x20–0x7F (memory) store and return all 8 written bits. In the trickle byte, an upper nibble of 0xA enables charging, bits 3..2 pick the diode count and bits 1..0 pick the resistor; the byte is only stored.
- R5: The control byte is at 0x0F. Its bits 5..3 always read as 0.
- R6: The status byte is at 0x10. Its bits 7..2 always read as 0.
- R7: While control bit 6 (write protect) is 1, writes to any address other than 0x0F are ignored. A write to 0x0F is always accepted, so it can clear the flag.
- R8: Addresses 0x12–0x1F read as 0x00 and ignore writes.
- R9: Dropping chip select ends the transaction. A byte that is only partly shifted in is never written, and the next transaction starts again with a command byte.
- R10: `miso_en` is 1 only while chip select is high and a read's data bytes are in progress. While `miso_en` is 0, `miso` is 0.
- R11: After reset every register reads as 0x00, and `miso` and `miso_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than sclk |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_en | output | 1 | High while the slave is returning read data |

## Verification
The bench uses the default parameters: two synchronizer stages and the package's 7-bit address map. This lets a short run reach both ends of the map: the 0x7F-to-0x00 wrap, the reserved gap next to the memory, and bursts that cross from the gap into the memory. The serial-clock half period is eight system clocks. That leaves margin after the synchronizer and edge-detect latency, so the one-byte look-ahead read load and the partial-byte abort are exercised at realistic timing.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int REG_COUNT = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h10;
    localparam logic [ADDR_W-1:0] GAP_LO    = 7'h12;
    localparam logic [ADDR_W-1:0] GAP_HI    = 7'h1F;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hC7;
    localparam logic [DATA_W-1:0] STAT_KEEP = 8'h03;
    localparam int                LOCK_BIT  = 6;

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    function automatic logic in_gap(input logic [ADDR_W-1:0] a);
        return (a >= GAP_LO) && (a <= GAP_HI);
    endfunction
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter
    import rtc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso_bit
);
    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-2:0] rx;
        logic [DATA_W-1:0] tx;
        logic              miso;
    } shf_t;

    shf_t shf_d, shf_q;
    logic rise, fall;

    always_comb begin
        rise      = ce_s &&  sclk_s && !shf_q.sclk_prev;
        fall      = ce_s && !sclk_s &&  shf_q.sclk_prev;
        byte_done = fall && (shf_q.cnt == CNT_W'(DATA_W-1));
        rx_byte   = {shf_q.rx, mosi_s};
        miso_bit  = shf_q.miso;

        shf_d           = shf_q;
        shf_d.sclk_prev = sclk_s;
        if (!ce_s) begin
            shf_d.cnt  = '0;
            shf_d.miso = 1'b0;
        end else begin
            if (rise) begin
                shf_d.miso = shf_q.tx[DATA_W-1];
                shf_d.tx   = {shf_q.tx[DATA_W-2:0], 1'b0};
            end
            if (fall) begin
                shf_d.rx  = {shf_q.rx[DATA_W-3:0], mosi_s};
                shf_d.cnt = shf_q.cnt + 1'b1;
            end
        end
        if (tx_load) begin
            shf_d.tx = tx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    // A new select window always starts on a byte boundary.
    assert_fresh_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_s) |-> (shf_q.cnt == '0));
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
    import rtc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    logic [DATA_W-1:0] mem_q [REG_COUNT];
    wr_t               wr_d;
    logic              lock;
    logic [DATA_W-1:0] keep;

    always_comb begin
        lock = mem_q[CTRL_ADDR][LOCK_BIT];
        case (waddr)
            CTRL_ADDR: keep = CTRL_KEEP;
            STAT_ADDR: keep = STAT_KEEP;
            default:   keep = '1;
        endcase
        wr_d.en   = we && !in_gap(waddr) && (!lock || (waddr == CTRL_ADDR));
        wr_d.addr = waddr;
        wr_d.data = wdata & keep;
        rdata     = in_gap(raddr) ? '0 : mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) mem_q[i] <= '0;
        end else if (wr_d.en) begin
            mem_q[wr_d.addr] <= wr_d.data;
        end
    end

    assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock && (waddr != CTRL_ADDR)) |=> (mem_q[$past(waddr)] == $past(mem_q[waddr])));
    assert_ctrl_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[CTRL_ADDR][5:3] == 3'b000);
    assert_stat_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[STAT_ADDR][7:2] == 6'b000000);
    assert_gap_stays_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_gap(waddr)) |=> (mem_q[$past(waddr)] == '0));
endmodule

// File: rtl/rtc_spi_slave.sv
module rtc_spi_slave
    import rtc_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output logic miso_en
);
    typedef struct packed {
        phase_e            phase;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [2:0]        pins_s;
    logic              ce_s, sclk_s, mosi_s;
    logic              byte_done, miso_bit, tx_load, reg_we;
    logic [DATA_W-1:0] rx_byte, rdata;
    logic [ADDR_W-1:0] raddr;

    rtc_spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({ce, sclk, mosi}), .sync_o(pins_s)
    );
    assign {ce_s, sclk_s, mosi_s} = pins_s;

    rtc_spi_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .tx_load(tx_load), .tx_data(rdata), .byte_done(byte_done),
        .rx_byte(rx_byte), .miso_bit(miso_bit)
    );

    rtc_spi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ctl_q.addr),
        .wdata(rx_byte), .raddr(raddr), .rdata(rdata)
    );

    always_comb begin
        ctl_d   = ctl_q;
        tx_load = 1'b0;
        reg_we  = 1'b0;
        raddr   = ctl_q.addr;
        if (!ce_s) begin
            ctl_d.phase = PH_CMD;
            ctl_d.is_wr = 1'b0;
        end else if (byte_done) begin
            if (ctl_q.phase == PH_CMD) begin
                ctl_d.phase = PH_DATA;
                ctl_d.is_wr = rx_byte[DATA_W-1];
                ctl_d.addr  = rx_byte[ADDR_W-1:0];
                raddr       = rx_byte[ADDR_W-1:0];
                tx_load     = !rx_byte[DATA_W-1];
            end else begin
                ctl_d.addr = ctl_q.addr + 1'b1;
                raddr      = ctl_q.addr + 1'b1;
                reg_we     = ctl_q.is_wr;
                tx_load    = !ctl_q.is_wr;
            end
        end
        miso_en = ce_s && (ctl_q.phase == PH_DATA) && !ctl_q.is_wr;
        miso    = miso_en && miso_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_CMD, is_wr: 1'b0, addr: '0};
        else        ctl_q <= ctl_d;
    end

    assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && byte_done && (ctl_q.phase == PH_DATA)) |=> (ctl_q.addr == $past(ctl_q.addr) + 1'b1));
    assert_cmd_opens_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && byte_done && (ctl_q.phase == PH_CMD)) |=> (ctl_q.phase == PH_DATA));
endmodule

// File: tb/rtc_spi_slave_tb.sv
module rtc_spi_slave_tb;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_en;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mdl [128];
    logic [7:0] wbuf [16];
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    rtc_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_en(miso_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compares bytes received by the driver against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, a, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    function automatic void model_write(input logic [6:0] a, input logic [7:0] d);
        if (a >= 7'h12 && a <= 7'h1F) return;
        if (mdl[15][6] && a != 7'h0F) return;
        if (a == 7'h0F)      mdl[a] = d & 8'hC7;
        else if (a == 7'h10) mdl[a] = d & 8'h03;
        else                 mdl[a] = d;
    endfunction

    task automatic cs_on();
        @(negedge clk); ce = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (H) @(negedge clk);
        ce = 1'b0; sclk = 1'b0;
        repeat (2*H) @(negedge clk);
    endtask

    task automatic shift(input logic [7:0] tx, input int nb, output logic [7:0] rx, output logic en_seen);
        rx = '0;
        en_seen = 1'b0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            rx[i] = miso;
            if (i == 7) en_seen = miso_en;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic spi_write(input logic [6:0] a, input int n);
        logic [7:0] r;
        logic en;
        logic [6:0] ad;
        cs_on();
        shift({1'b1, a}, 8, r, en);
        ad = a;
        for (int k = 0; k < n; k++) begin
            shift(wbuf[k], 8, r, en);
            if (k == 0) chk(en == 1'b0, "R10 miso_en during write", {7'd0, en}, 8'h00);
            model_write(ad, wbuf[k]);
            ad = ad + 7'd1;
        end
        cs_off();
    endtask

    task automatic spi_read(input logic [6:0] a, input int n, input string tag);
        logic [7:0] r;
        logic en;
        logic [6:0] ad;
        cs_on();
        shift({1'b0, a}, 8, r, en);
        chk(en == 1'b0, "R10 miso_en during command", {7'd0, en}, 8'h00);
        ad = a;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(mdl[ad]);
            tag_q.push_back(tag);
            shift(8'h00, 8, r, en);
            act_q.push_back(r);
            if (k == 0) chk(en == 1'b1, "R10 miso_en during read", {7'd0, en}, 8'h01);
            ad = ad + 7'd1;
        end
        cs_off();
    endtask

    initial begin
        logic [7:0] r;
        logic en;
        for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk(miso == 1'b0 && miso_en == 1'b0, "R11 outputs in reset", {6'd0, miso, miso_en}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(miso == 1'b0 && miso_en == 1'b0, "R11 outputs after reset", {6'd0, miso, miso_en}, 8'h00);

        spi_read(7'h00, 18, "R11 reset contents");
        spi_read(7'h7E, 4, "R11 reset memory");

        // Time bytes.
        wbuf[0] = 8'h59; wbuf[1] = 8'h58; wbuf[2] = 8'h23; wbuf[3] = 8'h07;
        wbuf[4] = 8'h31; wbuf[5] = 8'h12; wbuf[6] = 8'h99;
        spi_write(7'h00, 7);
        spi_read(7'h00, 7, "R1 R2 time burst");

        // Alarm banks.
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h80 + 8'(k*17);
        spi_write(7'h07, 8);
        spi_read(7'h07, 8, "R4 alarm bytes");

        // Trickle configuration and memory.
        wbuf[0] = 8'hA9;
        spi_write(7'h11, 1);
        spi_read(7'h11, 1, "R4 trickle byte");
        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
        spi_write(7'h20, 4);
        spi_read(7'h20, 4, "R4 memory burst");

        // Status reserved bits.
        wbuf[0] = 8'hFF;
        spi_write(7'h10, 1);
        spi_read(7'h10, 1, "R6 status reserved");

        // Control reserved bits and write protect.
        wbuf[0] = 8'hFF;
        spi_write(7'h0F, 1);
        spi_read(7'h0F, 1, "R5 control reserved");
        wbuf[0] = 8'h11;
        spi_write(7'h20, 1);
        wbuf[0] = 8'h00;
        spi_write(7'h00, 1);
        spi_read(7'h20, 1, "R7 locked memory");
        spi_read(7'h00, 1, "R7 locked time");
        wbuf[0] = 8'h00;
        spi_write(7'h0F, 1);
        wbuf[0] = 8'h77;
        spi_write(7'h20, 1);
        spi_read(7'h0F, 1, "R7 unlock control");
        spi_read(7'h20, 1, "R7 unlocked memory");

        // Reserved gap.
        wbuf[0] = 8'h55;
        spi_write(7'h15, 1);
        wbuf[0] = 8'h66; wbuf[1] = 8'h67; wbuf[2] = 8'h68;
        spi_write(7'h1E, 3);
        spi_read(7'h11, 16, "R8 gap reads zero");

        // Wrap.
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        spi_write(7'h7E, 3);
        spi_read(7'h7E, 3, "R3 wrap burst");

        // Abort inside a data byte, then inside a command byte.
        cs_on();
        shift(8'hA1, 8, r, en);
        shift(8'hFF, 4, r, en);
        cs_off();
        spi_read(7'h21, 1, "R9 partial byte dropped");
        cs_on();
        shift(8'hA2, 5, r, en);
        cs_off();
        wbuf[0] = 8'h3C;
        spi_write(7'h22, 1);
        spi_read(7'h22, 1, "R9 restart after abort");
        chk(miso == 1'b0 && miso_en == 1'b0, "R10 idle outputs", {6'd0, miso, miso_en}, 8'h00);

        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule